// File: doc/BRIEF.md
# Load/Store Unit with In-Order Access Queue

This unit takes load and store micro-operations, forms each effective address from a base register value plus a sign-extended 12-bit offset, and checks that the address is aligned to the access size. An aligned access goes into a small FIFO. A misaligned access never reaches memory. Instead, on the next cycle it raises an exception that carries the address-misaligned cause for a load or a store, together with the reorder-buffer index of the access.

Only the entry at the head of the queue talks to the data cache. It uses a valid/ready request channel and a valid/ready response channel, and only one request may be outstanding at any time. When the response handshake completes, the head leaves the queue. One cycle later the unit pulses a completion strobe with the reorder-buffer index. For a load, it also writes back the destination register number and the response data, zero- or sign-extended from the access width to 64 bits. A stall input freezes acceptance, request issue and response collection.

Top module: `ldst_queue_unit`

## Requirements
- R1: The request address equals the base input plus the 12-bit offset sign-extended to 64 bits. A store request carries the second-source data input unchanged on the request data output.
- R2: Access size is encoded 00 byte, 01 halfword, 10 word and 11 doubleword. The operation bit is 1 for a store and 0 for a load. Both encodings appear unchanged on the request.
- R3: An access is misaligned when its address is not a multiple of its size in bytes. Such an access issues no request. In the cycle after it is accepted, exc_valid pulses with cause 4 for a load or 6 for a store, and exc_rob_idx carries its index.
- R4: Requests leave in acceptance order, from the queue head only, with at most one awaiting a response. A request that is not accepted keeps its fields stable until it is accepted.
- R5: In the cycle after a response handshake, done pulses with the head's reorder-buffer index. For a load, ld_wb_valid also pulses with the destination register and the data. For a store, ld_wb_valid stays low.
- R6: Response data is right-justified. A load with in_unsigned = 1 is zero-extended from its width. Otherwise it is sign-extended from the top bit of its width.
- R7: accept_rdy is low exactly while DEPTH accesses are queued.
- R8: While stall is high, in_valid is ignored, req_valid is low and resp_ready is low.
- R9: After reset, accept_rdy is high and req_valid, resp_ready, done, ld_wb_valid and exc_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Freezes acceptance, issue and response collection |
| in_valid | input | 1 | A micro-op is presented |
| in_rob_idx | input | ROB_W | Reorder-buffer index |
| in_rd | input | 5 | Destination register |
| in_is_store | input | 1 | 1 store, 0 load |
| in_size | input | 2 | Access size code |
| in_unsigned | input | 1 | 1 zero-extends a load |
| in_base | input | XLEN | Base register value |
| in_imm | input | IMM_W | Address offset |
| in_wdata | input | XLEN | Store data |
| accept_rdy | output | 1 | Queue can take a micro-op |
| req_valid | output | 1 | Cache request valid |
| req_is_store | output | 1 | Request operation |
| req_size | output | 2 | Request size code |
| req_addr | output | XLEN | Request address |
| req_wdata | output | XLEN | Request store data |
| req_ready | input | 1 | Cache takes the request |
| resp_valid | input | 1 | Cache response valid |
| resp_data | input | XLEN | Right-justified response data |
| resp_ready | output | 1 | Unit takes the response |
| done | output | 1 | Completion strobe |
| done_rob_idx | output | ROB_W | Index of the completed access |
| ld_wb_valid | output | 1 | Load writeback strobe |
| ld_wb_rd | output | 5 | Writeback register |
| ld_wb_data | output | XLEN | Extended load data |
| exc_valid | output | 1 | Misalignment exception strobe |
| exc_cause | output | 5 | Exception cause |
| exc_rob_idx | output | ROB_W | Index of the faulting access |

## Verification
The assertions check on every cycle that the request is held while it waits, that no request appears while a response is awaited or during a stall, that every completion follows a response handshake, that every exception follows an acceptance and carries a legal cause, and that the queue never overfills. Only the bench scenarios can show the values themselves: they sweep every size, signedness, operation and low address offset, and show computed addresses, the width-dependent extension of load data, which addresses count as misaligned, strict issue order under random cache ready and latency, back-pressure when the queue is full, and that an access offered during a stall leaves no trace.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_DBL  = 2'b11
  } acc_size_e;

  localparam logic [4:0] CAUSE_LD_MISALIGN = 5'd4;
  localparam logic [4:0] CAUSE_ST_MISALIGN = 5'd6;
endpackage

// File: rtl/ldst_agen.sv
module ldst_agen #(
  parameter int XLEN  = 64,
  parameter int IMM_W = 12
) (
  input  logic [XLEN-1:0]  base,
  input  logic [IMM_W-1:0] imm,
  input  logic [1:0]       size,
  output logic [XLEN-1:0]  addr,
  output logic             misaligned
);
  import ldst_pkg::*;

  localparam int EXT_W = XLEN - IMM_W;

  assign addr = base + {{EXT_W{imm[IMM_W-1]}}, imm};

  always_comb begin
    case (acc_size_e'(size))
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = addr[0];
      SZ_WORD: misaligned = |addr[1:0];
      default: misaligned = |addr[2:0];
    endcase
  end
endmodule

// File: rtl/ldst_extend.sv
module ldst_extend #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] raw,
  input  logic [1:0]      size,
  input  logic            zero_ext,
  output logic [XLEN-1:0] value
);
  import ldst_pkg::*;

  logic fill;

  always_comb begin
    case (acc_size_e'(size))
      SZ_BYTE: begin
        fill  = ~zero_ext & raw[7];
        value = {{(XLEN-8){fill}}, raw[7:0]};
      end
      SZ_HALF: begin
        fill  = ~zero_ext & raw[15];
        value = {{(XLEN-16){fill}}, raw[15:0]};
      end
      SZ_WORD: begin
        fill  = ~zero_ext & raw[31];
        value = {{(XLEN-32){fill}}, raw[31:0]};
      end
      default: begin
        fill  = 1'b0;
        value = raw;
      end
    endcase
  end
endmodule

// File: rtl/ldst_fifo.sv
module ldst_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DEPTH-1:0] slot_we;

  always_comb begin
    wr_ptr_d = push ? wr_ptr_q + PW'(1) : wr_ptr_q;
    rd_ptr_d = pop  ? rd_ptr_q + PW'(1) : rd_ptr_q;
    cnt_d    = cnt_q;
    if (push && !pop) cnt_d = cnt_q + CW'(1);
    else if (pop && !push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign slot_we[g] = push && (wr_ptr_q == PW'(g));
    always_ff @(posedge clk) begin
      if (slot_we[g]) mem[g] <= din;
    end
  end

  assign dout  = mem[rd_ptr_q];
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign count = cnt_q;
endmodule

// File: rtl/ldst_queue_unit.sv
module ldst_queue_unit #(
  parameter int XLEN  = 64,
  parameter int IMM_W = 12,
  parameter int ROB_W = 4,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  input  logic             in_valid,
  input  logic [ROB_W-1:0] in_rob_idx,
  input  logic [4:0]       in_rd,
  input  logic             in_is_store,
  input  logic [1:0]       in_size,
  input  logic             in_unsigned,
  input  logic [XLEN-1:0]  in_base,
  input  logic [IMM_W-1:0] in_imm,
  input  logic [XLEN-1:0]  in_wdata,
  output logic             accept_rdy,
  output logic             req_valid,
  output logic             req_is_store,
  output logic [1:0]       req_size,
  output logic [XLEN-1:0]  req_addr,
  output logic [XLEN-1:0]  req_wdata,
  input  logic             req_ready,
  input  logic             resp_valid,
  input  logic [XLEN-1:0]  resp_data,
  output logic             resp_ready,
  output logic             done,
  output logic [ROB_W-1:0] done_rob_idx,
  output logic             ld_wb_valid,
  output logic [4:0]       ld_wb_rd,
  output logic [XLEN-1:0]  ld_wb_data,
  output logic             exc_valid,
  output logic [4:0]       exc_cause,
  output logic [ROB_W-1:0] exc_rob_idx
);
  import ldst_pkg::*;

  localparam int EW = ROB_W + 5 + 1 + 2 + 1 + 2 * XLEN;
  localparam int CW = $clog2(DEPTH+1);

  logic [XLEN-1:0] agen_addr, ext_data;
  logic            agen_mis;
  logic            q_full, q_empty;
  logic [CW-1:0]   q_cnt;
  logic [EW-1:0]   push_word, head_word;
  logic            take, push, pop, req_hs, resp_hs;

  logic [ROB_W-1:0] h_rob;
  logic [4:0]       h_rd;
  logic             h_st, h_uns;
  logic [1:0]       h_size;
  logic [XLEN-1:0]  h_addr, h_wdata;

  logic             busy_q, busy_d;
  logic             done_q, done_d, ldwb_q, ldwb_d, exc_q, exc_d;
  logic [ROB_W-1:0] done_rob_q, exc_rob_q;
  logic [4:0]       ldwb_rd_q, exc_cause_q, exc_cause_d;
  logic [XLEN-1:0]  ldwb_data_q;

  ldst_agen #(.XLEN(XLEN), .IMM_W(IMM_W)) agen_i (
    .base(in_base), .imm(in_imm), .size(in_size),
    .addr(agen_addr), .misaligned(agen_mis)
  );

  assign push_word = {in_rob_idx, in_rd, in_is_store, in_size, in_unsigned,
                      agen_addr, in_wdata};

  ldst_fifo #(.W(EW), .DEPTH(DEPTH)) queue_i (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .din(push_word), .dout(head_word),
    .full(q_full), .empty(q_empty), .count(q_cnt)
  );

  assign {h_rob, h_rd, h_st, h_size, h_uns, h_addr, h_wdata} = head_word;

  ldst_extend #(.XLEN(XLEN)) ext_i (
    .raw(resp_data), .size(h_size), .zero_ext(h_uns), .value(ext_data)
  );

  // acceptance, issue and response handshakes
  assign accept_rdy = ~q_full;
  assign take       = in_valid & ~stall & ~q_full;
  assign push       = take & ~agen_mis;
  assign req_valid  = ~q_empty & ~busy_q & ~stall;
  assign req_hs     = req_valid & req_ready;
  assign resp_ready = busy_q & ~stall;
  assign resp_hs    = resp_valid & resp_ready;
  assign pop        = resp_hs;

  assign req_is_store = h_st;
  assign req_size     = h_size;
  assign req_addr     = h_addr;
  assign req_wdata    = h_wdata;

  always_comb begin
    busy_d = busy_q;
    if (req_hs) busy_d = 1'b1;
    else if (resp_hs) busy_d = 1'b0;
    done_d      = resp_hs;
    ldwb_d      = resp_hs & ~h_st;
    exc_d       = take & agen_mis;
    exc_cause_d = in_is_store ? CAUSE_ST_MISALIGN : CAUSE_LD_MISALIGN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      ldwb_q      <= 1'b0;
      exc_q       <= 1'b0;
      done_rob_q  <= '0;
      ldwb_rd_q   <= '0;
      ldwb_data_q <= '0;
      exc_cause_q <= '0;
      exc_rob_q   <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      ldwb_q <= ldwb_d;
      exc_q  <= exc_d;
      if (resp_hs) begin
        done_rob_q  <= h_rob;
        ldwb_rd_q   <= h_rd;
        ldwb_data_q <= ext_data;
      end
      if (exc_d) begin
        exc_cause_q <= exc_cause_d;
        exc_rob_q   <= in_rob_idx;
      end
    end
  end

  assign done         = done_q;
  assign done_rob_idx = done_rob_q;
  assign ld_wb_valid  = ldwb_q;
  assign ld_wb_rd     = ldwb_rd_q;
  assign ld_wb_data   = ldwb_data_q;
  assign exc_valid    = exc_q;
  assign exc_cause    = exc_cause_q;
  assign exc_rob_idx  = exc_rob_q;
endmodule

// File: rtl/ldst_queue_unit_chk.sv
module ldst_queue_unit_chk #(
  parameter int XLEN  = 64,
  parameter int DEPTH = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            stall,
  input logic            in_valid,
  input logic            accept_rdy,
  input logic            req_valid,
  input logic            req_ready,
  input logic            req_is_store,
  input logic [1:0]      req_size,
  input logic [XLEN-1:0] req_addr,
  input logic            resp_valid,
  input logic            resp_ready,
  input logic            done,
  input logic            ld_wb_valid,
  input logic            exc_valid,
  input logic [4:0]      exc_cause,
  input logic [$clog2(DEPTH+1)-1:0] q_count
);
  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> stall ||
      (req_valid && $stable(req_addr) && $stable(req_size) && $stable(req_is_store)));

  // R4
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && resp_ready));

  // R8
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !req_valid && !resp_ready);

  // R5
  done_follows_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_ready |=> done);

  // R5
  done_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(resp_valid && resp_ready));

  // R5
  wb_within_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wb_valid |-> done);

  // R3
  exc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (exc_cause == 5'd4 || exc_cause == 5'd6));

  // R3
  exc_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> $past(in_valid && accept_rdy && !stall));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= ($clog2(DEPTH+1))'(DEPTH));
endmodule

bind ldst_queue_unit ldst_queue_unit_chk #(.XLEN(XLEN), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .stall(stall), .in_valid(in_valid),
  .accept_rdy(accept_rdy), .req_valid(req_valid), .req_ready(req_ready),
  .req_is_store(req_is_store), .req_size(req_size), .req_addr(req_addr),
  .resp_valid(resp_valid), .resp_ready(resp_ready), .done(done),
  .ld_wb_valid(ld_wb_valid), .exc_valid(exc_valid), .exc_cause(exc_cause),
  .q_count(q_cnt)
);

// File: tb/ldst_queue_unit_tb_top.sv
`timescale 1ns/1ps
module ldst_queue_unit_tb_top;
  localparam int XLEN = 64, IMM_W = 12, ROB_W = 4, DEPTH = 4, NOPS = 128;

  logic clk = 1'b0;
  logic rst_n;
  logic stall, in_valid, in_is_store, in_unsigned;
  logic [ROB_W-1:0] in_rob_idx;
  logic [4:0] in_rd;
  logic [1:0] in_size;
  logic [XLEN-1:0] in_base, in_wdata;
  logic [IMM_W-1:0] in_imm;
  logic accept_rdy, req_valid, req_is_store, req_ready, resp_valid, resp_ready;
  logic [1:0] req_size;
  logic [XLEN-1:0] req_addr, req_wdata, resp_data, ld_wb_data;
  logic done, ld_wb_valid, exc_valid;
  logic [ROB_W-1:0] done_rob_idx, exc_rob_idx;
  logic [4:0] ld_wb_rd, exc_cause;

  always #2 clk = ~clk;

  ldst_queue_unit #(.XLEN(XLEN), .IMM_W(IMM_W), .ROB_W(ROB_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .stall(stall), .in_valid(in_valid),
    .in_rob_idx(in_rob_idx), .in_rd(in_rd), .in_is_store(in_is_store),
    .in_size(in_size), .in_unsigned(in_unsigned), .in_base(in_base),
    .in_imm(in_imm), .in_wdata(in_wdata), .accept_rdy(accept_rdy),
    .req_valid(req_valid), .req_is_store(req_is_store), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_data(resp_data), .resp_ready(resp_ready),
    .done(done), .done_rob_idx(done_rob_idx), .ld_wb_valid(ld_wb_valid),
    .ld_wb_rd(ld_wb_rd), .ld_wb_data(ld_wb_data), .exc_valid(exc_valid),
    .exc_cause(exc_cause), .exc_rob_idx(exc_rob_idx)
  );

  int vectors = 0, fails = 0;
  int eptr = 0, rptr = 0, dptr = 0, cycles = 0;
  logic block_cache;

  logic [63:0] e_addr [256];
  logic [63:0] e_wdata [256];
  logic [63:0] e_ldval [256];
  logic [1:0]  e_size [256];
  logic        e_st [256];
  logic [3:0]  e_rob [256];
  logic [4:0]  e_rd [256];

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input logic [63:0] a);
    return 64'h8F7E_6D5C_CB3A_A998 ^ {8{a[7:0]}} ^ {a[31:0], a[31:0]};
  endfunction

  function automatic logic [63:0] extend(input logic [63:0] d, input logic [1:0] sz,
                                         input logic u);
    case (sz)
      2'd0: return u ? {56'd0, d[7:0]}  : {{56{d[7]}}, d[7:0]};
      2'd1: return u ? {48'd0, d[15:0]} : {{48{d[15]}}, d[15:0]};
      2'd2: return u ? {32'd0, d[31:0]} : {{32{d[31]}}, d[31:0]};
      default: return d;
    endcase
  endfunction

  function automatic bit misal(input logic [63:0] a, input logic [1:0] sz);
    return (sz == 2'd1 && a[0]) || (sz == 2'd2 && a[1:0] != 2'd0) ||
           (sz == 2'd3 && a[2:0] != 3'd0);
  endfunction

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", dptr, eptr);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  // data cache responder with random ready and latency
  initial begin
    logic [31:0] lf;
    bit busy_m, prev_resp;
    int lat, cur;
    lf = 32'h1ACE_B00C; busy_m = 0; prev_resp = 0; lat = 0; cur = 0;
    req_ready = 1'b0; resp_valid = 1'b0; resp_data = '0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (prev_resp) begin
        // R5 R6
        chk(done && done_rob_idx == e_rob[cur], "R5 done/rob",
            {59'd0, done, done_rob_idx}, {60'd1, e_rob[cur]});
        chk(ld_wb_valid == !e_st[cur], "R5 ld_wb_valid", 64'(ld_wb_valid), 64'(!e_st[cur]));
        if (!e_st[cur]) begin
          chk(ld_wb_rd == e_rd[cur], "R5 ld_wb_rd", 64'(ld_wb_rd), 64'(e_rd[cur]));
          chk(ld_wb_data == e_ldval[cur], "R6 load data", ld_wb_data, e_ldval[cur]);
        end
        dptr++;
      end else if (done) begin
        chk(1'b0, "R5 spurious done", 64'(done), 64'd0);
      end
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      if (busy_m && lat == 0) begin
        resp_valid = 1'b1;
        resp_data  = pat(e_addr[cur]);
      end else begin
        resp_valid = 1'b0;
        if (lat > 0) lat--;
      end
      req_ready = block_cache ? 1'b0 : lf[3];
      #1;
      prev_resp = resp_valid && resp_ready;
      if (prev_resp) busy_m = 0;
      if (req_valid && req_ready) begin
        // R1 R2 R4
        chk(req_addr == e_addr[rptr], "R1 address", req_addr, e_addr[rptr]);
        chk(req_size == e_size[rptr] && req_is_store == e_st[rptr], "R2 size/op",
            {61'd0, req_is_store, req_size}, {61'd0, e_st[rptr], e_size[rptr]});
        if (e_st[rptr])
          chk(req_wdata == e_wdata[rptr], "R1 store data", req_wdata, e_wdata[rptr]);
        cur = rptr;
        rptr++;
        busy_m = 1;
        lat = int'(lf[7:6]) % 3;
      end
    end
  end

  task automatic drive_op(input int i);
    logic [1:0] sz;
    logic u, st;
    logic [63:0] base, addr;
    logic [11:0] imm;
    bit mis;
    sz = 2'(i); u = i[2]; st = i[3];
    base = 64'h0000_0000_0002_0000 + 64'(i) * 64'd64;
    imm  = (i % 2 == 1) ? 12'hF80 + 12'(i[6:4]) : 12'h100 + 12'(i[6:4]);
    addr = base + {{52{imm[11]}}, imm};
    mis  = misal(addr, sz);
    while (!accept_rdy) @(negedge clk);
    in_valid = 1'b1; in_rob_idx = 4'(i); in_rd = 5'(i + 1); in_is_store = st;
    in_size = sz; in_unsigned = u; in_base = base; in_imm = imm;
    in_wdata = 64'hC3D2_E1F0_0F1E_2D3C ^ 64'(i * 977);
    if (!mis) begin
      e_addr[eptr] = addr; e_size[eptr] = sz; e_st[eptr] = st; e_rob[eptr] = 4'(i);
      e_rd[eptr] = 5'(i + 1); e_wdata[eptr] = in_wdata;
      e_ldval[eptr] = extend(pat(addr), sz, u);
      eptr++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    // R3
    chk(exc_valid == mis, "R3 exc_valid", 64'(exc_valid), 64'(mis));
    if (mis)
      chk(exc_cause == (st ? 5'd6 : 5'd4) && exc_rob_idx == 4'(i), "R3 cause/rob",
          {55'd0, exc_cause, exc_rob_idx}, {55'd0, (st ? 5'd6 : 5'd4), 4'(i)});
  endtask

  initial begin
    rst_n = 1'b0; stall = 1'b0; in_valid = 1'b0; in_rob_idx = '0; in_rd = '0;
    in_is_store = 1'b0; in_size = '0; in_unsigned = 1'b0; in_base = '0;
    in_imm = '0; in_wdata = '0; block_cache = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9
    chk(accept_rdy && !req_valid && !resp_ready && !done && !ld_wb_valid && !exc_valid,
        "R9 reset state", {58'd0, accept_rdy, req_valid, resp_ready, done, ld_wb_valid, exc_valid},
        64'h20);
    for (int i = 0; i < NOPS; i++) begin
      if (i == 64) begin
        // R8: misaligned load offered during stall must leave no trace
        stall = 1'b1; in_valid = 1'b1; in_size = 2'd1; in_is_store = 1'b0;
        in_base = 64'h0000_0000_0003_0001; in_imm = '0; in_rob_idx = 4'd15;
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          chk(!req_valid && !resp_ready && !exc_valid, "R8 stall freeze",
              {61'd0, req_valid, resp_ready, exc_valid}, 64'd0);
        end
        stall = 1'b0; in_valid = 1'b0;
      end
      drive_op(i);
      if (i == DEPTH - 1) begin
        // R7
        chk(!accept_rdy, "R7 full back-pressure", 64'(accept_rdy), 64'd0);
        block_cache = 1'b0;
      end
    end
    while (dptr < eptr) @(negedge clk);
    repeat (10) @(negedge clk);
    // R4
    chk(dptr == eptr && rptr == eptr, "R4 order/count", 64'(dptr), 64'(eptr));
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule